// File: doc/BRIEF.md
# Comparator Event Filter with Overflow-Paced Debounce

This block watches the one-bit output of an analog comparator and raises a sticky event flag when that output meets a selected condition: low level, high level, falling edge, rising edge or any toggle. The comparator bit first passes through a two-stage synchronizer. After that it is examined once per clock. Software clears the flag. The interrupt request is the flag gated by an interrupt enable, so the flag can be polled or used to interrupt.

In debounce mode the flag is not set at once. A qualifying transition starts a wait, and the wait is paced by overflow pulses from a free-running timer that other logic shares. The overflow pulse seen in the same cycle as the transition does not count. When the second counted overflow arrives, the comparator bit is sampled again. The flag is set only if that sample still equals the level the transition moved to. Because the timer is free-running, the filter delay lies between one and two timer periods. The filter can be told to stop while the system is idle, and it always stops in power-down.

Top module: `cmp_event_filter`

## Requirements
- R1: A change on `cmp_in` passes through two synchronizer flops. In the non-debounced modes, the flag rises at the third rising clock edge after the change, counting the edge that captures the change.
- R2: `mode` selects the condition: 3'b000 low level, 3'b001 high level, 3'b010 falling edge, 3'b011 rising edge, 3'b100 any toggle. Codes 3'b101 to 3'b111 never set the flag. With `dbnc_en`=0, level modes set the flag on every working cycle in which the synchronized bit has the selected level. Edge modes set it on the cycle in which the matching change is seen.
- R3: The filter is working when `enable`=1, `pdown`=0, and either `idle`=0 or `idle_run`=1. On the first working cycle after a stop, the synchronized bit is only stored as a reference. No edge is detected on that cycle.
- R4: The flag stays set until a cycle with `flag_clr`=1. A clear and a hardware set in the same cycle leave the flag set. A clear takes effect even while the filter is stopped.
- R5: `irq` equals `flag` AND `irq_en`. This is the wake-up request while idle with `idle_run`=1.
- R6: With `dbnc_en`=1, only a change of the synchronized bit starts a wait. The change qualifies if its new value is 0 for modes 000 and 010, 1 for modes 001 and 011, or either value for mode 100. An `ovf_pulse` in the same cycle as the change is not counted. On the cycle of the second counted pulse, the flag is set only if the synchronized bit equals the new value. Otherwise the event is discarded and watching resumes.
- R7: In debounce mode, the flag can only become set on a cycle in which `ovf_pulse`=1. Changes seen during a wait neither restart it nor start another.
- R8: With `idle`=1 and `idle_run`=0 the flag is never set. With `idle_run`=1 the filter works normally during idle.
- R9: With `pdown`=1 the flag is never set, whatever `idle_run` is.
- R10: Stopping the filter abandons a pending debounce wait. Overflow pulses after a restart cannot complete it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Raw comparator output |
| enable | input | 1 | Filter enable |
| mode | input | 3 | Condition select |
| dbnc_en | input | 1 | Debounce enable |
| idle | input | 1 | System idle indication |
| pdown | input | 1 | Power-down indication |
| idle_run | input | 1 | Keep the filter working during idle |
| ovf_pulse | input | 1 | One-cycle overflow pulse from the shared timer |
| flag_clr | input | 1 | Software clear of the flag |
| irq_en | input | 1 | Interrupt enable |
| flag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt / wake-up request |

## Verification
On every cycle, the assertions check the following:
- the flag stays sticky unless a clear arrives;
- the flag never rises while the filter is disabled, idle without permit, or in power-down;
- in debounce mode, the flag rises only on an overflow cycle;
- the request never appears without the flag.

Some behaviour only the bench scenarios can show. These are the per-mode condition decoding, the latency through the synchronizer, and that the first sample after enable is only a reference. The bench also shows that the same-cycle overflow is not counted, that a glitch which reverts before the second overflow is discarded, and that a stop abandons a pending wait.

// File: rtl/cmp_event_filter.sv
module cmp_event_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int OVF_NEED    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_in,
  input  logic       enable,
  input  logic [2:0] mode,
  input  logic       dbnc_en,
  input  logic       idle,
  input  logic       pdown,
  input  logic       idle_run,
  input  logic       ovf_pulse,
  input  logic       flag_clr,
  input  logic       irq_en,
  output logic       flag,
  output logic       irq
);
  localparam int CW = (OVF_NEED < 2) ? 1 : $clog2(OVF_NEED);

  logic [SYNC_STAGES-1:0] sync_q;
  logic          cur, prev_q, ref_ok_q, waiting_q, expect_q;
  logic [CW-1:0] ovf_cnt_q;
  logic          active, rise, fall, hit, qual, last_ovf, set_ev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_in};

  assign cur    = sync_q[SYNC_STAGES-1];
  assign active = enable & ~pdown & (~idle | idle_run);
  assign rise   = ref_ok_q & ~prev_q & cur;
  assign fall   = ref_ok_q & prev_q & ~cur;

  always_comb begin
    hit  = 1'b0;
    qual = 1'b0;
    case (mode)
      3'b000:  begin hit = ~cur;        qual = fall;        end
      3'b001:  begin hit = cur;         qual = rise;        end
      3'b010:  begin hit = fall;        qual = fall;        end
      3'b011:  begin hit = rise;        qual = rise;        end
      3'b100:  begin hit = rise | fall; qual = rise | fall; end
      default: begin hit = 1'b0;        qual = 1'b0;        end
    endcase
  end

  assign last_ovf = waiting_q & ovf_pulse & (ovf_cnt_q == CW'(OVF_NEED - 1));
  assign set_ev   = active & (dbnc_en ? (last_ovf & (cur == expect_q)) : hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      ref_ok_q  <= 1'b0;
      waiting_q <= 1'b0;
      expect_q  <= 1'b0;
      ovf_cnt_q <= '0;
    end else if (!active) begin
      ref_ok_q  <= 1'b0;
      waiting_q <= 1'b0;
      ovf_cnt_q <= '0;
    end else begin
      ref_ok_q <= 1'b1;
      prev_q   <= cur;
      if (!dbnc_en) begin
        waiting_q <= 1'b0;
        ovf_cnt_q <= '0;
      end else if (!waiting_q) begin
        if (qual) begin
          waiting_q <= 1'b1;
          expect_q  <= cur;
          ovf_cnt_q <= '0;
        end
      end else if (ovf_pulse) begin
        if (last_ovf) begin
          waiting_q <= 1'b0;
          ovf_cnt_q <= '0;
        end else begin
          ovf_cnt_q <= ovf_cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag <= 1'b0;
    else        flag <= set_ev | (flag & ~flag_clr);

  assign irq = flag & irq_en;
endmodule

// File: rtl/cmp_event_filter_chk.sv
module cmp_event_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic dbnc_en,
  input logic idle,
  input logic pdown,
  input logic idle_run,
  input logic ovf_pulse,
  input logic flag_clr,
  input logic flag,
  input logic irq
);
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !flag) |=> !flag);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !idle_run && !flag) |=> !flag);

  assert_pdown_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown && !flag) |=> !flag);

  assert_dbnc_on_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbnc_en && !ovf_pulse && !flag) |=> !flag);
endmodule

bind cmp_event_filter cmp_event_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .dbnc_en(dbnc_en), .idle(idle),
  .pdown(pdown), .idle_run(idle_run), .ovf_pulse(ovf_pulse),
  .flag_clr(flag_clr), .flag(flag), .irq(irq)
);

// File: tb/sim_cmp_event_filter.sv
`timescale 1ns/1ps
module sim_cmp_event_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp_in = 0, enable = 0, dbnc_en = 0, idle = 0, pdown = 0, idle_run = 0;
  logic ovf_pulse = 0, flag_clr = 0, irq_en = 0;
  logic [2:0] mode = 3'b000;
  logic flag, irq;
  int checks = 0, errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  cmp_event_filter u0 (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .enable(enable), .mode(mode),
    .dbnc_en(dbnc_en), .idle(idle), .pdown(pdown), .idle_run(idle_run),
    .ovf_pulse(ovf_pulse), .flag_clr(flag_clr), .irq_en(irq_en),
    .flag(flag), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr_pulse();
    flag_clr = 1; step(1); flag_clr = 0;
  endtask

  task automatic ovf();
    ovf_pulse = 1; step(1); ovf_pulse = 0;
  endtask

  task automatic park(input logic v);
    enable = 0; cmp_in = v; step(4); clr_pulse(); step(1);
  endtask

  function automatic logic lvl(input int m, input logic v);
    return (m == 0) ? !v : (m == 1) ? v : 1'b0;
  endfunction

  function automatic logic edg(input int m, input logic a, input logic b);
    return (a != b) && ((m == 2 && !b) || (m == 3 && b) || m == 4);
  endfunction

  function automatic logic qual(input int m, input logic a, input logic b);
    return (a != b) && (((m == 0 || m == 2) && !b) || ((m == 1 || m == 3) && b) || m == 4);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    chk(flag, 0, "reset flag");
    chk(irq, 0, "reset irq");
    rst_n = 1; step(2);

    // R1 latency: high level, change at negedge, flag at third posedge
    mode = 3'b001; park(0); enable = 1; step(3);
    cmp_in = 1; step(2);
    chk(flag, 0, "R1 not before third edge");
    step(1);
    chk(flag, 1, "R1 at third edge");

    // R2 R3 R5: non-debounced sweep over modes 0..7 and two-sample patterns
    dbnc_en = 0;
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 4; p++) begin
        logic a, b, e;
        a = p[0]; b = p[1];
        mode = m[2:0]; irq_en = p[0] ^ p[1] ^ m[0];
        park(a);
        chk(flag, 0, "R4 clear while stopped");
        enable = 1; step(4);
        e = lvl(m, a);
        chk(flag, e, "R3 R2 reference sample");
        clr_pulse();
        cmp_in = b; step(4);
        e = lvl(m, a) | lvl(m, b) | edg(m, a, b);
        chk(flag, e, "R2 condition");
        chk(irq, e & irq_en, "R5 irq gating");
      end

    // R4 set wins over clear
    mode = 3'b001; park(1); enable = 1; step(4);
    clr_pulse(); step(1);
    chk(flag, 1, "R4 set wins");
    mode = 3'b011; clr_pulse(); step(1);
    chk(flag, 0, "R4 clear");

    // R6 R7 debounce sweep, with and without glitch
    dbnc_en = 1;
    for (int m = 0; m < 5; m++)
      for (int p = 0; p < 8; p++) begin
        logic a, b, g;
        a = p[0]; b = p[1]; g = p[2];
        mode = m[2:0];
        park(a);
        enable = 1; step(4);
        chk(flag, 0, "R6 no flag without transition");
        cmp_in = b; step(3);
        ovf(); step(2);
        chk(flag, 0, "R6 one overflow not enough");
        if (g) cmp_in = a;
        step(4);
        ovf(); step(1);
        chk(flag, qual(m, a, b) & !g, "R6 R7 resample after two overflows");
      end

    // R6 overflow in the same cycle as the transition is not counted
    mode = 3'b011; park(0); enable = 1; step(4);
    cmp_in = 1; step(2);
    ovf(); step(2);
    ovf(); step(2);
    chk(flag, 0, "R6 same-cycle overflow ignored");
    ovf(); step(1);
    chk(flag, 1, "R6 set on second counted overflow");

    // R10 stop abandons pending wait
    mode = 3'b011; park(0); enable = 1; step(4);
    cmp_in = 1; step(3);
    ovf(); step(1);
    enable = 0; step(2); enable = 1; step(2);
    ovf(); step(2); ovf(); step(2);
    chk(flag, 0, "R10 wait abandoned");

    // R8 idle, R9 power-down
    dbnc_en = 0; mode = 3'b001; irq_en = 1;
    park(1); idle = 1; idle_run = 0; enable = 1; step(6);
    chk(flag, 0, "R8 idle without permit");
    idle_run = 1; step(3);
    chk(flag, 1, "R8 idle with permit");
    chk(irq, 1, "R5 wake request");
    clr_pulse(); pdown = 1; step(1); clr_pulse(); step(4);
    chk(flag, 0, "R9 power-down");
    pdown = 0; idle = 0; step(3);
    chk(flag, 1, "R9 resumes");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule